// File: doc/BRIEF.md
# Two-Level Local History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two tables. The first is a per-branch history table. It is selected by low bits of the branch address, and each entry is a shift register of that branch's recent outcomes. The value read from that entry then selects one two-bit saturating counter in a pattern table. The counter's upper bit is the prediction. A lookup therefore makes two chained table reads, and both are combinational within the same cycle.

When a branch resolves, the execute stage presents its address and its outcome on the update port. The block then steps the counter that the entry's old history selects toward that outcome, and shifts the outcome into the history entry. The history table has no tags, so branches whose selected address bits are equal share one history entry. The table sizes and the history length are parameters.

Top module: `local_hist_pred`

## Requirements
- R1: The history entry used is `pc[ALIGN_W +: IDX_W]` (defaults: bits 7:2). Two addresses that agree in those bits share one entry, whatever their other bits are.
- R2: `lk_taken` is combinational from `lk_pc` in the same cycle. It equals bit 1 of the counter selected by the history value stored at the lookup entry.
- R3: The counter encoding is 0 strongly not taken, 1 weakly not taken, 2 weakly taken and 3 strongly taken. A taken update adds 1, saturating at 3. A not-taken update subtracts 1, saturating at 0.
- R4: An update steps the counter selected by the history entry's value from before that update.
- R5: On an update, the history entry shifts left by one. The outcome (1 = taken) enters bit 0 and the oldest bit is dropped.
- R6: A synchronous active-low reset clears every history entry to 0 and sets every counter to 1, so every lookup then predicts not taken.
- R7: If a lookup and an update touch the same entries in one cycle, the lookup returns the values from before the update.
- R8: While `up_valid` is low, no table changes, whatever values `up_pc` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest case to reach from the ports is a pattern counter that is selected by a long, specific history and then pushed into saturation. A history only holds a value after exactly the right run of outcomes for that one entry, and each update changes the history that selects the next counter. The stimulus gets there with directed runs on one address: long all-taken runs, alternating runs, and runs on an aliasing pair of addresses. These sit between random updates drawn from a small address pool, so entries and counters collide often. A bench model of both tables predicts every lookup, including lookups that coincide with an update to the same entry.

// File: rtl/lhp_pkg.sv
// Package lhp_pkg
// Shared counter type and its saturating step function for the local
// history predictor. Assumes a two-bit counter whose upper bit is the
// predicted direction.
package lhp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    // Move one step toward the outcome, holding at both ends.
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lhp_hist_table.sv
// Module lhp_hist_table
// Per-branch outcome history storage. One asynchronous read port serves
// lookup. A second read port gives the old value at the update entry,
// which is the value the counter update must use. A write shifts the
// outcome into bit 0. Assumes one update per cycle at most.
module lhp_hist_table #(
    parameter int IDX_W = 6,
    parameter int HL    = 6,
    localparam int N    = 1 << IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [HL-1:0]    rd_hist,
    input  logic            wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic            wr_bit,
    output logic [HL-1:0]    wr_old,
    output logic [N*HL-1:0]  state_flat
);

    logic [HL-1:0] hist_q [N];
    logic [HL-1:0] shifted;

    // Read both ports from the stored (pre-update) contents.
    always_comb begin
        rd_hist = hist_q[rd_idx];
        wr_old  = hist_q[wr_idx];
        shifted = (wr_old << 1) | HL'(wr_bit);
    end

    // Clear on reset, otherwise shift the outcome into the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) hist_q[i] <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= shifted;
        end
    end

    // Expose the stored state as one vector for the checker.
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign state_flat[g*HL +: HL] = hist_q[g];
    end

endmodule

// File: rtl/lhp_pattern_table.sv
// Module lhp_pattern_table
// Two-bit saturating counters selected by a history value. There is one
// asynchronous lookup read and one read-modify-write update per cycle.
// Assumes the update index is the pre-update history of the branch.
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HL = 6,
    localparam int N = 1 << HL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HL-1:0] rd_idx,
    output ctr_e          rd_ctr,
    input  logic          wr_en,
    input  logic [HL-1:0] wr_idx,
    input  logic          wr_taken,
    output logic [2*N-1:0] state_flat
);

    ctr_e ctr_q [N];
    ctr_e wr_next;

    // Lookup read and the next value of the updated counter.
    always_comb begin
        rd_ctr  = ctr_q[rd_idx];
        wr_next = ctr_step(ctr_q[wr_idx], wr_taken);
    end

    // Set to weakly not taken on reset, otherwise step on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ctr_q[i] <= CTR_WNT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_next;
        end
    end

    // Expose the stored state as one vector for the checker.
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign state_flat[2*g +: 2] = ctr_q[g];
    end

endmodule

// File: rtl/local_hist_pred.sv
// Module local_hist_pred
// Local two-level direction predictor. The lookup address selects a
// history entry. That history selects a counter, and the counter's upper
// bit is the prediction. Both reads are combinational. An update steps the
// counter that the old history selects and shifts the outcome into the
// history. Assumes at most one resolved branch per cycle and no tags.
module local_hist_pred
    import lhp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6,
    parameter int HL      = 6,
    localparam int HN     = 1 << IDX_W,
    localparam int PN     = 1 << HL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [HL-1:0]    lk_hist, up_hist;
    ctr_e             lk_ctr;
    logic [HN*HL-1:0] hist_flat;
    logic [2*PN-1:0]  ctr_flat;

    // Pick the history entry from the address bits above the alignment.
    always_comb begin
        lk_idx = lk_pc[ALIGN_W +: IDX_W];
        up_idx = up_pc[ALIGN_W +: IDX_W];
    end

    lhp_hist_table #(.IDX_W(IDX_W), .HL(HL)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (lk_idx),
        .rd_hist    (lk_hist),
        .wr_en      (up_valid),
        .wr_idx     (up_idx),
        .wr_bit     (up_taken),
        .wr_old     (up_hist),
        .state_flat (hist_flat)
    );

    lhp_pattern_table #(.HL(HL)) u_pat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (lk_hist),
        .rd_ctr     (lk_ctr),
        .wr_en      (up_valid),
        .wr_idx     (up_hist),
        .wr_taken   (up_taken),
        .state_flat (ctr_flat)
    );

    // The counter's upper bit gives the direction.
    assign lk_taken = lk_ctr[1];

endmodule

// File: rtl/lhp_chk.sv
// Module lhp_chk
// Checker bound to local_hist_pred. It registers each update, then compares
// the table state one cycle later against the step and shift rules. It
// also ties the lookup output to the stored tables.
module lhp_chk #(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6,
    parameter int HL      = 6,
    localparam int HN     = 1 << IDX_W,
    localparam int PN     = 1 << HL
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken,
    input logic [HN*HL-1:0] hist_flat,
    input logic [2*PN-1:0]  ctr_flat
);

    logic             v_q, t_q, was_rst;
    logic [IDX_W-1:0] hidx_q;
    logic [HL-1:0]    hold_q, cidx_q;
    logic [1:0]       cold_q;
    logic [HN*HL-1:0] hist_prev;
    logic [2*PN-1:0]  ctr_prev;
    logic [HL-1:0]    hist_now, lk_h;
    logic [1:0]       ctr_now, ctr_exp;
    logic [IDX_W-1:0] cur_up_idx, cur_lk_idx;
    logic [HL-1:0]    cur_up_hist;

    // Decode the present update and lookup against the stored state.
    always_comb begin
        cur_up_idx  = up_pc[ALIGN_W +: IDX_W];
        cur_lk_idx  = lk_pc[ALIGN_W +: IDX_W];
        cur_up_hist = hist_flat[cur_up_idx*HL +: HL];
        lk_h        = hist_flat[cur_lk_idx*HL +: HL];
        hist_now    = hist_flat[hidx_q*HL +: HL];
        ctr_now     = ctr_flat[cidx_q*2 +: 2];
        if (t_q) ctr_exp = (cold_q == 2'd3) ? 2'd3 : cold_q + 2'd1;
        else     ctr_exp = (cold_q == 2'd0) ? 2'd0 : cold_q - 2'd1;
    end

    // Capture each update and the state before it.
    always_ff @(posedge clk) begin
        was_rst   <= !rst_n;
        v_q       <= up_valid;
        t_q       <= up_taken;
        hidx_q    <= cur_up_idx;
        hold_q    <= cur_up_hist;
        cidx_q    <= cur_up_hist;
        cold_q    <= ctr_flat[cur_up_hist*2 +: 2];
        hist_prev <= hist_flat;
        ctr_prev  <= ctr_flat;
    end

    // R3
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !was_rst) |-> (ctr_now == ctr_exp));

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !was_rst) |-> (hist_now == ((hold_q << 1) | HL'(t_q))));

    // R2
    lookup_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken == ctr_flat[lk_h*2 + 1]);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_q && !was_rst) |-> (hist_flat == hist_prev && ctr_flat == ctr_prev));

    // R6
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (hist_flat == '0 && !lk_taken));

endmodule

bind local_hist_pred lhp_chk #(
    .PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .HL(HL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .up_valid  (up_valid),
    .up_pc     (up_pc),
    .up_taken  (up_taken),
    .hist_flat (hist_flat),
    .ctr_flat  (ctr_flat)
);

// File: tb/local_hist_pred_tb.sv
// Bench for local_hist_pred: directed corner runs plus seeded random
// traffic. Each lookup is checked against a bench model of both tables.
module local_hist_pred_tb;

    localparam int PC_W = 32, ALIGN_W = 2, IDX_W = 6, HL = 6;
    localparam int HN = 1 << IDX_W, PN = 1 << HL;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
    logic            up_valid = 1'b0, up_taken = 1'b0;
    logic            lk_taken;

    int checks = 0, errors = 0;
    int m_hist [HN];
    int m_ctr  [PN];

    always #5 clk = ~clk;

    local_hist_pred #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .HL(HL)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'(pc[ALIGN_W +: IDX_W]);
    endfunction

    function automatic logic model_pred(input logic [PC_W-1:0] pc);
        return (m_ctr[m_hist[idx_of(pc)]] >= 2);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < HN; i++) m_hist[i] = 0;
        for (int i = 0; i < PN; i++) m_ctr[i] = 1;
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input logic t);
        int h;
        h = m_hist[idx_of(pc)];
        if (t) m_ctr[h] = (m_ctr[h] == 3) ? 3 : m_ctr[h] + 1;
        else   m_ctr[h] = (m_ctr[h] == 0) ? 0 : m_ctr[h] - 1;
        m_hist[idx_of(pc)] = ((h << 1) | int'(t)) & (PN - 1);
    endtask

    // One cycle: drive, check the lookup before the edge, then update the model.
    task automatic step(input string tag, input logic [PC_W-1:0] lpc,
                        input logic v, input logic [PC_W-1:0] upc, input logic t);
        logic exp;
        @(negedge clk);
        lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
        #2;
        exp = model_pred(lpc);
        checks++;
        if (lk_taken !== exp) begin
            errors++;
            $display("FAIL %s: pc=%h actual=%b expected=%b", tag, lpc, lk_taken, exp);
        end
        if (v) model_update(upc, t);
    endtask

    initial begin
        logic [PC_W-1:0] pool [8];
        logic [PC_W-1:0] a, b;
        int r;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R6: after reset every lookup predicts not taken
        for (int i = 0; i < 6; i++) step("R6", PC_W'(i * 52 + 4), 1'b0, '0, 1'b0);

        // R3 R4: long taken run saturates the all-ones counter, then backs off
        a = 32'h0000_1040;
        for (int i = 0; i < 12; i++) step("R3", a, 1'b1, a, 1'b1);
        for (int i = 0; i < 4; i++)  step("R4", a, 1'b1, a, 1'b0);
        for (int i = 0; i < 8; i++)  step("R3", a, 1'b1, a, 1'b0);

        // R5: alternating outcomes are learned per history pattern
        b = 32'h0000_2088;
        for (int i = 0; i < 24; i++) step("R5", b, 1'b1, b, 1'(i % 2));

        // R7: lookup on the entry being updated sees the old values
        for (int i = 0; i < 10; i++) step("R7", a, 1'b1, a, 1'b1);

        // R8: update strobe low, random address and outcome, nothing changes
        for (int i = 0; i < 10; i++) step("R8", a, 1'b0, $urandom, 1'($urandom));

        // R1: addresses that differ only above the index bits share history
        for (int i = 0; i < 8; i++) step("R1", a + 32'h100, 1'b1, a + 32'h4000_0000, 1'b0);

        // R2: seeded random traffic on a small aliasing pool
        for (int i = 0; i < 8; i++)
            pool[i] = {$urandom} & 32'h0000_00fc | ((i % 2) ? 32'h0001_0000 : 32'h0);
        pool[1] = pool[0] | 32'h0100_0000;
        for (int i = 0; i < 3000; i++) begin
            r = $urandom_range(0, 7);
            step("R2", pool[$urandom_range(0, 7)], 1'($urandom_range(0, 3) != 0),
                 pool[r], 1'($urandom_range(0, 2) != 0 || r < 2));
        end

        // R6: reset mid-run restores the initial prediction
        @(negedge clk); rst_n = 1'b0; up_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 8; i++) step("R6", pool[i], 1'b0, '0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule